// File: doc/BRIEF.md
# Output Pixel Buffer with Repetition and Segmentation

This block sits at the end of a display pipe, just before the link encoder. It takes a stream of pixels with a valid/ready handshake and a marker on the last pixel of each frame. It sends the pixels on, also with a valid/ready handshake. The block can repeat each pixel a programmed number of times. It can tag every pixel with the panel segment it belongs to when the line is split into one, two or four segments. Pixels close to a segment boundary can be emitted for both segments that share that boundary.

For stereoscopic timing, the block counts eye images using the frame marker. After the first eye image it inserts a programmed number of gap lines filled with a programmable dummy colour, and holds the input off while it does so. Both the frame-packed layout and the frame-alternate layout have their own gap-length setting. Configuration inputs are expected to stay constant while a frame is in flight.

Top module: `pixel_out_buffer`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and no gap is in progress.
- R2: With `cfg_repeat` = r, every copy of a pixel is sent r+1 times in a row. `in_ready` stays low until the last of those beats is accepted.
- R3: With `cfg_repeat` = 0 and no overlap copy, one pixel passes per cycle while `out_ready` is high. `in_ready` never drops in that case.
- R4: `cfg_seg_mode` selects the segmentation: 0 gives one segment, 1 gives two, 2 gives four. The line holds `cfg_active_width` pixels. Segment length S is the line length divided by the segment count, and `out_seg` is the pixel's position in the line divided by S.
- R5: `cfg_seg_mode` = 3 is the split left/right four-segment mode. The line holds twice `cfg_active_width` pixels, and each segment holds half of `cfg_active_width`.
- R6: The overlap count v is `cfg_overlap` capped at 8, and is 0 for a single segment. A pixel in the last v positions of any segment except the last is sent twice: first tagged with its own segment, then with the next segment. Both copies have `out_overlap` = 1, and repetition applies to each copy.
- R7: When `cfg_active_width` is not a multiple of the segment count (4 for modes 2 and 3), `cfg_err` is 1. The block then works as one segment, with `out_seg` = 0 and no overlap.
- R8: `out_eol` is 1 only on the final beat of the last pixel position of a line. `out_eof` is 1 only on the final beat of a pixel that came in with `in_eof`.
- R9: With `cfg_stereo` = 1 (frame packed), after the first eye image the block sends `cfg_gap_packed` lines of `cfg_active_width` beats. These beats carry `{cfg_dummy_r,cfg_dummy_g,cfg_dummy_b}`, `out_gap` = 1, `out_seg` = 0 and `out_eol` on each line's last beat, and `in_ready` stays low meanwhile. No gap follows the second eye image.
- R10: With `cfg_stereo` = 2 (frame alternate), the gap length is taken from `cfg_gap_alt` instead. With `cfg_stereo` = 0, no gap lines are inserted.
- R11: While `out_valid` is 1 and `out_ready` is 0, every output field holds its value.
- R12: A selected gap length of 0 inserts no gap lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_active_width | input | WIDTH_W | Programmed active width in pixels |
| cfg_repeat | input | REP_W | Extra repetitions per pixel |
| cfg_seg_mode | input | 2 | Segmentation mode |
| cfg_overlap | input | OVL_W | Overlap pixels per boundary |
| cfg_stereo | input | 2 | 0 off, 1 frame packed, 2 frame alternate |
| cfg_gap_packed | input | LINES_W | Gap lines in frame-packed mode |
| cfg_gap_alt | input | LINES_W | Gap lines in frame-alternate mode |
| cfg_dummy_r | input | CHAN_W | Gap fill, red |
| cfg_dummy_g | input | CHAN_W | Gap fill, green |
| cfg_dummy_b | input | CHAN_W | Gap fill, blue |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted |
| in_data | input | 3*CHAN_W | Input pixel |
| in_eof | input | 1 | Last pixel of a frame or eye image |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts beat |
| out_data | output | 3*CHAN_W | Output pixel |
| out_seg | output | 2 | Segment index |
| out_overlap | output | 1 | Beat is an overlap copy |
| out_eol | output | 1 | Final beat of a line |
| out_eof | output | 1 | Final beat of a frame |
| out_gap | output | 1 | Beat is a dummy gap pixel |
| cfg_err | output | 1 | Width not divisible by segment count |

## Verification
The stream is checked beat by beat against a model built from the requirements. The cases cover:
- plain one-segment lines, which set the baseline;
- heavy repetition, which shows that copies are counted correctly and do not merge across pixels;
- two-segment, four-segment and split modes with several overlap depths, including a cap that covers an entire segment, which separate boundary placement from overlap ordering;
- indivisible widths, which show the fallback apart from normal single-segment operation.

Random backpressure on some runs shows that the held beat stays stable. Stall counts taken at full throughput separate repetition stalls from overlap stalls. The stereo runs compare the packed and alternate gap lengths, a disabled stereo mode and a zero-length gap, so that choosing the wrong gap register or placing the gap wrongly shows up in the output.

// File: rtl/pob_pkg.sv
package pob_pkg;
  localparam int SEG_W = 2;

  typedef enum logic [1:0] {
    SEG_ONE     = 2'd0,
    SEG_TWO     = 2'd1,
    SEG_FOUR    = 2'd2,
    SEG_FOUR_LR = 2'd3
  } seg_mode_e;

  typedef enum logic [1:0] {
    STEREO_OFF    = 2'd0,
    STEREO_PACKED = 2'd1,
    STEREO_ALT    = 2'd2,
    STEREO_RSVD   = 2'd3
  } stereo_e;

  typedef enum logic {
    PH_PIX = 1'b0,
    PH_GAP = 1'b1
  } phase_e;
endpackage

// File: rtl/pob_cfg_decode.sv
module pob_cfg_decode
  import pob_pkg::*;
#(
  parameter int WIDTH_W = 12,
  parameter int OVL_W   = 4,
  parameter int MAX_OVL = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [WIDTH_W-1:0]   active_w,
  input  logic [1:0]           seg_mode,
  input  logic [OVL_W-1:0]     overlap,
  output logic [WIDTH_W:0]     line_len,
  output logic [WIDTH_W:0]     seg_len,
  output logic [SEG_W-1:0]     seg_last,
  output logic [OVL_W-1:0]     ovl_eff,
  output logic                 cfg_err
);
  localparam int LW = WIDTH_W + 1;
  localparam logic [OVL_W-1:0] OVL_CAP = OVL_W'(MAX_OVL);

  seg_mode_e          mode;
  logic [OVL_W-1:0]   ovl_clip;

  assign mode     = seg_mode_e'(seg_mode);
  assign ovl_clip = (overlap > OVL_CAP) ? OVL_CAP : overlap;

  always_comb begin
    line_len = (mode == SEG_FOUR_LR) ? {active_w, 1'b0} : {1'b0, active_w};
    cfg_err  = 1'b0;
    seg_len  = line_len;
    seg_last = '0;
    ovl_eff  = '0;
    unique case (mode)
      SEG_ONE: ;
      SEG_TWO: begin
        cfg_err = active_w[0];
        if (!cfg_err) begin
          seg_len  = LW'(active_w >> 1);
          seg_last = 2'd1;
          ovl_eff  = ovl_clip;
        end
      end
      SEG_FOUR: begin
        cfg_err = |active_w[1:0];
        if (!cfg_err) begin
          seg_len  = LW'(active_w >> 2);
          seg_last = 2'd3;
          ovl_eff  = ovl_clip;
        end
      end
      SEG_FOUR_LR: begin
        cfg_err = |active_w[1:0];
        if (!cfg_err) begin
          seg_len  = LW'(active_w >> 1);
          seg_last = 2'd3;
          ovl_eff  = ovl_clip;
        end
      end
    endcase
  end

  AST_SPLIT_QUARTER: assert property (@(posedge clk) disable iff (rst)
    (mode == SEG_FOUR_LR && !cfg_err) |-> ((LW+2)'(line_len) == {seg_len, 2'b00})); // R5

  AST_FALLBACK_ONE: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> (seg_last == '0 && ovl_eff == '0)); // R7
endmodule

// File: rtl/pob_seg_track.sv
module pob_seg_track
  import pob_pkg::*;
#(
  parameter int WIDTH_W = 12,
  parameter int OVL_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               take,
  input  logic               take_eof,
  input  logic [WIDTH_W:0]   line_len,
  input  logic [WIDTH_W:0]   seg_len,
  input  logic [SEG_W-1:0]   seg_last,
  input  logic [OVL_W-1:0]   ovl_eff,
  output logic [SEG_W-1:0]   seg_idx,
  output logic               seg_dup,
  output logic               line_end
);
  localparam int LW = WIDTH_W + 1;

  logic [LW-1:0] pos_x;
  logic [LW-1:0] pos_off;

  assign line_end = (pos_x == line_len - 1'b1);
  assign seg_dup  = (ovl_eff != '0) && (seg_idx != seg_last) &&
                    (((LW+1)'(pos_off) + (LW+1)'(ovl_eff)) >= (LW+1)'(seg_len));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_x   <= '0;
      pos_off <= '0;
      seg_idx <= '0;
    end else if (take) begin
      if (take_eof || line_end) begin
        pos_x   <= '0;
        pos_off <= '0;
        seg_idx <= '0;
      end else begin
        pos_x <= pos_x + 1'b1;
        if (pos_off == seg_len - 1'b1) begin
          pos_off <= '0;
          seg_idx <= seg_idx + 1'b1;
        end else begin
          pos_off <= pos_off + 1'b1;
        end
      end
    end
  end

  AST_SEG_LIMIT: assert property (@(posedge clk) disable iff (rst)
    seg_idx <= seg_last); // R4

  AST_OFF_LIMIT: assert property (@(posedge clk) disable iff (rst)
    pos_off < seg_len); // R4
endmodule

// File: rtl/pixel_out_buffer.sv
module pixel_out_buffer
  import pob_pkg::*;
#(
  parameter int CHAN_W  = 10,
  parameter int WIDTH_W = 12,
  parameter int REP_W   = 4,
  parameter int OVL_W   = 4,
  parameter int LINES_W = 8,
  parameter int MAX_OVL = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WIDTH_W-1:0]    cfg_active_width,
  input  logic [REP_W-1:0]      cfg_repeat,
  input  logic [1:0]            cfg_seg_mode,
  input  logic [OVL_W-1:0]      cfg_overlap,
  input  logic [1:0]            cfg_stereo,
  input  logic [LINES_W-1:0]    cfg_gap_packed,
  input  logic [LINES_W-1:0]    cfg_gap_alt,
  input  logic [CHAN_W-1:0]     cfg_dummy_r,
  input  logic [CHAN_W-1:0]     cfg_dummy_g,
  input  logic [CHAN_W-1:0]     cfg_dummy_b,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [3*CHAN_W-1:0]   in_data,
  input  logic                  in_eof,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [3*CHAN_W-1:0]   out_data,
  output logic [SEG_W-1:0]      out_seg,
  output logic                  out_overlap,
  output logic                  out_eol,
  output logic                  out_eof,
  output logic                  out_gap,
  output logic                  cfg_err
);
  localparam int LW = WIDTH_W + 1;

  logic [LW-1:0]      line_len;
  logic [LW-1:0]      seg_len;
  logic [SEG_W-1:0]   seg_last;
  logic [OVL_W-1:0]   ovl_eff;
  logic [SEG_W-1:0]   trk_seg;
  logic               trk_dup;
  logic               trk_end;

  phase_e             st;
  stereo_e            stereo;
  logic [REP_W-1:0]   rep_cnt;
  logic               second;
  logic               cur_dup;
  logic               cur_line_end;
  logic               cur_eof;
  logic               gap_armed;
  logic               eye;
  logic [WIDTH_W-1:0] gap_x;
  logic [LINES_W-1:0] gap_left;

  logic               last_rep;
  logic               final_beat;
  logic               advance;
  logic               hold_copy;
  logic               take;
  logic               stereo_on;
  logic [LINES_W-1:0] gap_sel;
  logic               first_final;
  logic               next_final;

  pob_cfg_decode #(.WIDTH_W(WIDTH_W), .OVL_W(OVL_W), .MAX_OVL(MAX_OVL)) u_dec (
    .clk      (clk),
    .rst      (rst),
    .active_w (cfg_active_width),
    .seg_mode (cfg_seg_mode),
    .overlap  (cfg_overlap),
    .line_len (line_len),
    .seg_len  (seg_len),
    .seg_last (seg_last),
    .ovl_eff  (ovl_eff),
    .cfg_err  (cfg_err)
  );

  pob_seg_track #(.WIDTH_W(WIDTH_W), .OVL_W(OVL_W)) u_trk (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .take_eof (in_eof),
    .line_len (line_len),
    .seg_len  (seg_len),
    .seg_last (seg_last),
    .ovl_eff  (ovl_eff),
    .seg_idx  (trk_seg),
    .seg_dup  (trk_dup),
    .line_end (trk_end)
  );

  assign stereo      = stereo_e'(cfg_stereo);
  assign stereo_on   = (stereo == STEREO_PACKED) || (stereo == STEREO_ALT);
  assign gap_sel     = (stereo == STEREO_PACKED) ? cfg_gap_packed : cfg_gap_alt;
  assign last_rep    = (rep_cnt == cfg_repeat);
  assign final_beat  = out_gap || (last_rep && (!cur_dup || second));
  assign advance     = !out_valid || out_ready;
  assign hold_copy   = out_valid && !final_beat;
  assign in_ready    = advance && (st == PH_PIX) && !hold_copy && !gap_armed;
  assign take        = in_valid && in_ready;
  assign first_final = (cfg_repeat == '0) && !trk_dup;

  always_comb begin
    if (last_rep) next_final = (cfg_repeat == '0);
    else          next_final = ((rep_cnt + 1'b1) == cfg_repeat) && (!cur_dup || second);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_data     <= '0;
      out_seg      <= '0;
      out_overlap  <= 1'b0;
      out_eol      <= 1'b0;
      out_eof      <= 1'b0;
      out_gap      <= 1'b0;
      st           <= PH_PIX;
      rep_cnt      <= '0;
      second       <= 1'b0;
      cur_dup      <= 1'b0;
      cur_line_end <= 1'b0;
      cur_eof      <= 1'b0;
      gap_armed    <= 1'b0;
      eye          <= 1'b0;
      gap_x        <= '0;
      gap_left     <= '0;
    end else if (advance) begin
      if (hold_copy) begin
        if (last_rep) begin
          rep_cnt <= '0;
          second  <= 1'b1;
          out_seg <= out_seg + 1'b1;
        end else begin
          rep_cnt <= rep_cnt + 1'b1;
        end
        out_eol <= cur_line_end && next_final;
        out_eof <= cur_eof && next_final;
      end else if (st == PH_GAP) begin
        out_valid   <= 1'b1;
        out_gap     <= 1'b1;
        out_data    <= {cfg_dummy_r, cfg_dummy_g, cfg_dummy_b};
        out_seg     <= '0;
        out_overlap <= 1'b0;
        out_eof     <= 1'b0;
        rep_cnt     <= '0;
        second      <= 1'b0;
        cur_dup     <= 1'b0;
        out_eol     <= (gap_x == cfg_active_width - 1'b1);
        if (gap_x == cfg_active_width - 1'b1) begin
          gap_x    <= '0;
          gap_left <= gap_left - 1'b1;
          if (gap_left == LINES_W'(1)) st <= PH_PIX;
        end else begin
          gap_x <= gap_x + 1'b1;
        end
      end else if (gap_armed) begin
        gap_armed <= 1'b0;
        st        <= PH_GAP;
        gap_x     <= '0;
        gap_left  <= gap_sel;
        out_valid <= 1'b0;
      end else if (take) begin
        out_valid    <= 1'b1;
        out_gap      <= 1'b0;
        out_data     <= in_data;
        out_seg      <= trk_seg;
        out_overlap  <= trk_dup;
        cur_dup      <= trk_dup;
        rep_cnt      <= '0;
        second       <= 1'b0;
        cur_line_end <= trk_end;
        cur_eof      <= in_eof;
        out_eol      <= trk_end && first_final;
        out_eof      <= in_eof && first_final;
        if (in_eof && stereo_on) begin
          eye <= ~eye;
          if (!eye && gap_sel != '0) gap_armed <= 1'b1;
        end
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_seg) &&
      $stable(out_overlap) && $stable(out_eol) && $stable(out_eof) && $stable(out_gap))); // R11

  AST_GAP_STALL: assert property (@(posedge clk) disable iff (rst)
    (st == PH_GAP) |-> !in_ready); // R9

  AST_GAP_FIELDS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_gap) |-> (!out_overlap && out_seg == '0 && !out_eof)); // R9

  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cfg_err && !out_gap) |-> (out_seg == '0 && !out_overlap)); // R7

  AST_OVL_NEXT_SEG: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && cur_dup && !second && last_rep) |=>
      (out_valid && out_overlap && out_seg == $past(out_seg) + 1'b1)); // R6

  AST_REP_BOUND: assert property (@(posedge clk) disable iff (rst)
    rep_cnt <= cfg_repeat); // R2
endmodule

// File: tb/pixel_out_buffer_test.sv
module pixel_out_buffer_test;
  localparam int CHAN_W  = 10;
  localparam int WIDTH_W = 12;
  localparam int REP_W   = 4;
  localparam int OVL_W   = 4;
  localparam int LINES_W = 8;
  localparam int MAXB    = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [WIDTH_W-1:0] cfg_active_width = 12'd8;
  logic [REP_W-1:0]   cfg_repeat = '0;
  logic [1:0]         cfg_seg_mode = 2'd0;
  logic [OVL_W-1:0]   cfg_overlap = '0;
  logic [1:0]         cfg_stereo = 2'd0;
  logic [LINES_W-1:0] cfg_gap_packed = '0;
  logic [LINES_W-1:0] cfg_gap_alt = '0;
  logic [CHAN_W-1:0]  cfg_dummy_r = 10'h155;
  logic [CHAN_W-1:0]  cfg_dummy_g = 10'h0AA;
  logic [CHAN_W-1:0]  cfg_dummy_b = 10'h3C3;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [3*CHAN_W-1:0] in_data = '0;
  logic               in_eof = 1'b0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [3*CHAN_W-1:0] out_data;
  logic [1:0]         out_seg;
  logic               out_overlap, out_eol, out_eof, out_gap, cfg_err;

  always #10 clk = ~clk;

  pixel_out_buffer #(.CHAN_W(CHAN_W), .WIDTH_W(WIDTH_W), .REP_W(REP_W),
                     .OVL_W(OVL_W), .LINES_W(LINES_W)) uut (
    .clk(clk), .rst(rst),
    .cfg_active_width(cfg_active_width), .cfg_repeat(cfg_repeat),
    .cfg_seg_mode(cfg_seg_mode), .cfg_overlap(cfg_overlap),
    .cfg_stereo(cfg_stereo), .cfg_gap_packed(cfg_gap_packed), .cfg_gap_alt(cfg_gap_alt),
    .cfg_dummy_r(cfg_dummy_r), .cfg_dummy_g(cfg_dummy_g), .cfg_dummy_b(cfg_dummy_b),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_eof(in_eof),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_seg(out_seg), .out_overlap(out_overlap), .out_eol(out_eol),
    .out_eof(out_eof), .out_gap(out_gap), .cfg_err(cfg_err)
  );

  int checks = 0;
  int failures = 0;
  logic [35:0] exp_q [0:MAXB-1];
  int exp_n;
  int exp_stall;
  logic [29:0] dummy_px;

  // width, repeat, seg mode, overlap, lines, backpressure, expected error
  localparam int NV = 10;
  localparam int VECS [0:NV-1][0:6] = '{
    '{ 8,  0, 0, 0, 2, 0, 0},  // R3 R4 plain single segment
    '{ 8,  2, 0, 0, 1, 0, 0},  // R2 repetition
    '{ 8,  0, 1, 2, 2, 0, 0},  // R4 R6 two segments, overlap 2
    '{ 8,  1, 2, 1, 1, 1, 0},  // R4 R6 R11 four segments, backpressure
    '{ 8,  0, 3, 3, 1, 0, 0},  // R5 split left/right
    '{ 6,  0, 2, 2, 1, 0, 1},  // R7 width not divisible by four
    '{ 7,  1, 1, 1, 1, 1, 1},  // R7 odd width, two segments
    '{ 8, 15, 1, 1, 1, 0, 0},  // R2 R6 max repeat with overlap
    '{16,  0, 1, 12, 1, 0, 0}, // R6 overlap capped at 8
    '{ 8,  0, 1, 0, 1, 1, 0}   // R4 R8 R11 two segments, no overlap
  };

  function automatic logic [29:0] pix(int k);
    return 30'(k * 37 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic build_exp(input int w, input int rep, input int mode, input int ov,
                           input int st, input int g1, input int g2, input int lines,
                           input int eyes, output int err);
    int ll, n, s, ovl, k, ptot;
    ll = (mode == 3) ? 2 * w : w;
    n = (mode == 0) ? 1 : ((mode == 1) ? 2 : 4);
    err = ((w % n) != 0) ? 1 : 0;
    if (err != 0) n = 1;
    s = ll / n;
    ovl = (n == 1) ? 0 : ((ov > 8) ? 8 : ov);
    exp_n = 0; exp_stall = 0; k = 0;
    ptot = ll * lines * eyes;
    for (int e = 0; e < eyes; e++) begin
      for (int ln = 0; ln < lines; ln++) begin
        for (int x = 0; x < ll; x++) begin
          int seg, off, dup;
          bit lastpix;
          seg = x / s; off = x % s;
          dup = (ovl != 0 && seg < n - 1 && off >= s - ovl) ? 1 : 0;
          lastpix = (ln == lines - 1) && (x == ll - 1);
          for (int p = 0; p <= dup; p++) begin
            for (int r = 0; r <= rep; r++) begin
              bit lastc;
              lastc = (p == dup) && (r == rep);
              exp_q[exp_n] = {1'b0, lastpix && lastc, (x == ll - 1) && lastc,
                              dup[0], 2'(seg + p), pix(k)};
              exp_n++;
            end
          end
          if (k != ptot - 1) exp_stall += (dup + 1) * (rep + 1) - 1;
          k++;
        end
      end
      if ((st == 1 || st == 2) && e == 0) begin
        int g;
        g = (st == 1) ? g1 : g2;
        for (int gl = 0; gl < g; gl++)
          for (int gx = 0; gx < w; gx++) begin
            exp_q[exp_n] = {1'b1, 1'b0, gx == w - 1, 1'b0, 2'd0, dummy_px};
            exp_n++;
          end
      end
    end
  endtask

  task automatic run_case(input int w, input int rep, input int mode, input int ov,
                          input int st, input int g1, input int g2, input int lines,
                          input int eyes, input int bp, input int xerr, input string tag);
    int ll, ptot, in_idx, out_idx, cyc, stalls, err;
    logic [7:0] lf;
    logic [35:0] held;
    bit held_v;
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    cfg_active_width = WIDTH_W'(w);
    cfg_repeat = REP_W'(rep);
    cfg_seg_mode = 2'(mode);
    cfg_overlap = OVL_W'(ov);
    cfg_stereo = 2'(st);
    cfg_gap_packed = LINES_W'(g1);
    cfg_gap_alt = LINES_W'(g2);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    build_exp(w, rep, mode, ov, st, g1, g2, lines, eyes, err);
    ll = (mode == 3) ? 2 * w : w;
    ptot = ll * lines * eyes;
    in_idx = 0; out_idx = 0; cyc = 0; stalls = 0; lf = 8'hA5; held_v = 1'b0; held = '0;
    while (out_idx < exp_n && cyc < 20000) begin
      @(negedge clk);
      out_ready = (bp != 0) ? (lf[0] | lf[3]) : 1'b1;
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      in_valid = (in_idx < ptot);
      in_data = pix(in_idx);
      in_eof = ((in_idx + 1) % (ll * lines)) == 0;
      #1;
      if (held_v) begin
        // R11: beat holds while stalled
        check({out_valid, out_gap, out_eof, out_eol, out_overlap, out_seg, out_data} == {1'b1, held},
              {"R11 hold ", tag}, {out_gap, out_eof, out_eol, out_overlap, out_seg, out_data}, held);
        held_v = 1'b0;
      end
      if (out_valid && !out_ready) begin
        held = {out_gap, out_eof, out_eol, out_overlap, out_seg, out_data};
        held_v = 1'b1;
      end
      if (out_valid && out_ready) begin
        // R4 R5 R6 R8 R9 beat contents
        check({out_gap, out_eof, out_eol, out_overlap, out_seg, out_data} == exp_q[out_idx],
              {"R2/R4/R5/R6/R8/R9 beat ", tag},
              {out_gap, out_eof, out_eol, out_overlap, out_seg, out_data}, exp_q[out_idx]);
        out_idx++;
      end
      if (in_valid && !in_ready) stalls++;
      if (in_valid && in_ready) in_idx++;
      cyc++;
    end
    check(cyc < 20000, {"R2 watchdog per case ", tag}, 64'(cyc), 64'(20000));
    check(out_idx == exp_n, {"R2/R9 beat count ", tag}, 64'(out_idx), 64'(exp_n));
    check(in_idx == ptot, {"R2 input count ", tag}, 64'(in_idx), 64'(ptot));
    check(cfg_err == xerr[0] && err == xerr, {"R7 error flag ", tag}, 64'(cfg_err), 64'(xerr));
    if (bp == 0 && st == 0)
      check(stalls == exp_stall, {"R2/R3 stall cycles ", tag}, 64'(stalls), 64'(exp_stall));
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    repeat (12) @(negedge clk);
    #1;
    // R10 R12: no extra beats after the stream
    check(!out_valid, {"R10/R12 no trailing beats ", tag}, 64'(out_valid), 64'd0);
  endtask

  initial begin
    #(20 * 190000);
    failures++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    dummy_px = {cfg_dummy_r, cfg_dummy_g, cfg_dummy_b};
    // R1: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready, "R1 in_ready after reset", 64'(in_ready), 64'd1);
    check(!out_gap, "R1 no gap after reset", 64'(out_gap), 64'd0);

    for (int v = 0; v < NV; v++)
      run_case(VECS[v][0], VECS[v][1], VECS[v][2], VECS[v][3], 0, 0, 0,
               VECS[v][4], 1, VECS[v][5], VECS[v][6], $sformatf("vec%0d", v));

    // R9: frame packed gap after first eye only
    run_case(4, 1, 1, 1, 1, 2, 5, 2, 2, 0, 0, "packed");
    run_case(4, 0, 0, 0, 1, 3, 1, 1, 2, 1, 0, "packed_bp");
    // R10: alternate layout takes the second length, stereo off inserts none
    run_case(4, 1, 1, 1, 2, 2, 1, 2, 2, 0, 0, "alternate");
    run_case(4, 0, 0, 0, 0, 2, 2, 2, 2, 0, 0, "stereo_off");
    // R12: zero gap length
    run_case(4, 0, 1, 1, 1, 0, 3, 1, 2, 0, 0, "gap_zero");

    // R1: reset in the middle of a repeated pixel
    @(negedge clk);
    rst = 1'b1;
    cfg_repeat = 4'd5; cfg_seg_mode = 2'd0; cfg_stereo = 2'd0; cfg_active_width = 12'd8;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b1; in_data = pix(3); in_eof = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid, "R2 repeat in progress before reset", 64'(out_valid), 64'd1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1;
    check(!out_valid, "R1 out_valid after mid-run reset", 64'(out_valid), 64'd0);
    check(in_ready, "R1 in_ready after mid-run reset", 64'(in_ready), 64'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule